// File: doc/BRIEF.md
# Transmit Frame Assembler

This block collects one outgoing Ethernet frame. A host writes the frame as 32-bit words, and the block stores them least significant byte first in a single-port RAM. The block decides when the frame leaves and streams it out as bytes with a valid/ready/last handshake. The first word written while the buffer is empty is a header word. Its low halfword gives the payload length, and the payload length excludes the 14-byte MAC header.

The block launches the frame in one of two ways. Automatic launch needs two tests to pass together: a programmable fill threshold and a completeness test that accounts for an optional trailing CRC word. A transmit command launches the frame unconditionally. The outgoing byte count is the payload length plus 14. When padding is enabled, short frames are filled with zero bytes up to 60. Two single-cycle pulses go to an interrupt block: one for an oversize length word and one for a buffer that has emptied after a send.

Top module: `tx_frame_assembler`

## Requirements
- R1: Each accepted word is stored at the current fill offset, bits [7:0] at the lowest byte address. Streamed byte j comes from buffer byte offset j+2, so the length halfword itself is never sent.
- R2: A word written while the fill level is 0 is a length word. If bits [15:0] exceed DEPTH-16 (2032 by default), the word is not stored and the fill level stays 0. `err_pulse` is then high for exactly the cycle after that write.
- R3: The frame is complete when the fill level (in bytes) is at least L+16, where L is the payload length. The required level is L+20 when `cfg_crc_auto` is 0, and is capped at DEPTH.
- R4: The threshold test passes only when `cfg_thr` is not 6'h3F and the fill level is at least 32*`cfg_thr`+4 bytes.
- R5: Automatic launch is evaluated only on a write that is accepted and not rejected by R2. If R3 and R4 both pass with the post-write fill level, `m_valid` rises in the next cycle. Otherwise no frame starts.
- R6: A one-cycle `tx_go` while idle launches the frame regardless of R3 and R4, with `m_valid` rising in the next cycle.
- R7: The frame carries L+14 bytes, capped at DEPTH-2, and `m_last` marks its final byte.
- R8: With `cfg_pad_en` set and L+14 below 60, the frame is 60 bytes long. Every byte from position L+14 onward is zero.
- R9: In the cycle after the handshake of the last byte, `empty_pulse` is high for one cycle, `m_valid` is low, the fill level is 0 and `wr_ready` is high.
- R10: An `err_ack` pulse while idle returns the fill level to 0. The next word written is then treated as a length word.
- R11: A write that would raise the fill level above DEPTH is discarded without changing stored data.
- R12: `wr_ready` is low while a frame is streaming. While `m_valid` is high and `m_ready` is low, `m_data` and `m_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pad_en | input | 1 | Pad short frames to 60 bytes with zeros |
| cfg_crc_auto | input | 1 | 1: no CRC word expected in the buffer |
| cfg_thr | input | 6 | Fill threshold code; 6'h3F disables automatic launch |
| wr_valid | input | 1 | Host data word valid |
| wr_data | input | 32 | Host data word |
| wr_ready | output | 1 | Block can accept a data word |
| tx_go | input | 1 | Explicit transmit command |
| err_ack | input | 1 | Acknowledge length error; clears the fill level |
| m_valid | output | 1 | Outgoing byte valid |
| m_data | output | 8 | Outgoing byte |
| m_last | output | 1 | Final byte of the frame |
| m_ready | input | 1 | Downstream accepts the byte |
| err_pulse | output | 1 | Oversize length word seen |
| empty_pulse | output | 1 | Frame fully sent, buffer empty |

## Verification
The bench hits the completeness boundary exactly. A design off by one word would either launch a word early or stall until a command arrives. Both length-word cases are covered: the largest legal length, which must be accepted, and one byte more, which must be rejected without advancing the fill level. A design that stored the oversize word would shift every later byte.

The error-acknowledge and full-buffer cases make misbehaviour visible in the stream. A fill level that is not cleared puts the next header at the wrong offset. A write that wraps past a full buffer overwrites the bytes sent first. Padding is checked byte by byte, so stale buffer contents appearing past the payload are caught. A threshold set beyond the buffer size is also exercised; there, only the command can send.

// File: rtl/txfa_pkg.sv
package txfa_pkg;

    localparam int unsigned PREFIX_BYTES = 2;
    localparam int unsigned HDR_BYTES    = 14;
    localparam int unsigned CRC_BYTES    = 4;
    localparam int unsigned MIN_FRAME    = 60;
    localparam logic [5:0]  THR_OFF      = 6'h3F;

    typedef enum logic {ST_FILL, ST_SEND} txfa_state_e;

    typedef struct packed {
        logic       pad_en;
        logic       crc_auto;
        logic [5:0] thr;
    } txfa_cfg_t;

    // bytes needed in the buffer before the frame counts as complete
    function automatic logic [31:0] need_bytes(input logic [15:0] len,
                                               input logic crc_auto,
                                               input int unsigned depth);
        logic [31:0] n;
        n = {16'd0, len} + 32'(PREFIX_BYTES + HDR_BYTES);
        if (!crc_auto) n = n + 32'(CRC_BYTES);
        if (n > 32'(depth)) n = 32'(depth);
        return n;
    endfunction

    // fill level at which the threshold code is met
    function automatic logic [31:0] thr_bytes(input logic [5:0] thr);
        return ({26'd0, thr} << 5) + 32'd4;
    endfunction

    // outgoing byte count
    function automatic logic [31:0] frame_bytes(input logic [15:0] len,
                                                input logic pad_en,
                                                input int unsigned depth);
        logic [31:0] f;
        f = {16'd0, len} + 32'(HDR_BYTES);
        if (pad_en && f < 32'(MIN_FRAME)) f = 32'(MIN_FRAME);
        if (f > 32'(depth - PREFIX_BYTES)) f = 32'(depth - PREFIX_BYTES);
        return f;
    endfunction

endpackage

// File: rtl/txfa_ram.sv
module txfa_ram #(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned WORDS = DEPTH / 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    output logic [7:0]    rbyte
);
    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[addr[AW-1:2]] <= wdata;
    end

    always_comb rbyte = mem[addr[AW-1:2]][8*addr[1:0] +: 8];
endmodule

// File: rtl/txfa_eval.sv
module txfa_eval
    import txfa_pkg::*;
#(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned FW = $clog2(DEPTH) + 1
) (
    input  logic [FW-1:0] fill,
    input  logic [15:0]   len,
    input  txfa_cfg_t     cfg,
    output logic          auto_ok,
    output logic [15:0]   flen,
    output logic [15:0]   pay_end
);
    logic [31:0] fill32;
    logic        thr_ok;
    logic        complete;
    logic [31:0] f32;

    always_comb begin
        fill32   = {{(32-FW){1'b0}}, fill};
        thr_ok   = (cfg.thr != THR_OFF) && (fill32 >= thr_bytes(cfg.thr));
        complete = fill32 >= need_bytes(len, cfg.crc_auto, DEPTH);
        auto_ok  = thr_ok && complete;
        f32      = frame_bytes(len, cfg.pad_en, DEPTH);
        flen     = f32[15:0];
        pay_end  = len + 16'(HDR_BYTES);
    end
endmodule

// File: rtl/txfa_stream.sv
module txfa_stream #(
    parameter int unsigned AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [15:0]   flen,
    input  logic [15:0]   pay_end,
    input  logic [7:0]    ram_byte,
    input  logic          m_ready,
    output logic          m_valid,
    output logic [7:0]    m_data,
    output logic          m_last,
    output logic [AW-1:0] rd_addr,
    output logic          done
);
    logic        active_q;
    logic [15:0] idx_q;
    logic [15:0] flen_q;
    logic [15:0] pend_q;

    always_comb begin
        m_valid = active_q;
        m_last  = active_q && (idx_q == flen_q - 16'd1);
        m_data  = (idx_q >= pend_q) ? 8'h00 : ram_byte;
        rd_addr = AW'(idx_q + 16'd2);
        done    = active_q && m_ready && m_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            flen_q   <= '0;
            pend_q   <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            flen_q   <= flen;
            pend_q   <= pay_end;
        end else if (active_q && m_ready) begin
            if (m_last) active_q <= 1'b0;
            else        idx_q    <= idx_q + 16'd1;
        end
    end

    // R12
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

    // R9
    one_last_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !m_valid);
endmodule

// File: rtl/tx_frame_assembler.sv
module tx_frame_assembler
    import txfa_pkg::*;
#(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned AW      = $clog2(DEPTH),
    localparam int unsigned FW      = AW + 1,
    localparam int unsigned MAX_LEN = DEPTH - PREFIX_BYTES - HDR_BYTES
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_pad_en,
    input  logic        cfg_crc_auto,
    input  logic [5:0]  cfg_thr,
    input  logic        wr_valid,
    input  logic [31:0] wr_data,
    output logic        wr_ready,
    input  logic        tx_go,
    input  logic        err_ack,
    output logic        m_valid,
    output logic [7:0]  m_data,
    output logic        m_last,
    input  logic        m_ready,
    output logic        err_pulse,
    output logic        empty_pulse
);
    txfa_state_e   state_q;
    logic [FW-1:0] fill_q, fill_nxt;
    logic [15:0]   len_q, len_nxt;
    logic          err_q, empty_q;
    txfa_cfg_t     cfg;

    logic          wr_fire, first, len_bad, room, store, launch;
    logic          auto_ok, done;
    logic [15:0]   flen, pay_end;
    logic [AW-1:0] rd_addr, ram_addr;
    logic [7:0]    ram_byte;

    always_comb begin
        cfg      = '{pad_en: cfg_pad_en, crc_auto: cfg_crc_auto, thr: cfg_thr};
        wr_ready = (state_q == ST_FILL);
        wr_fire  = wr_valid && wr_ready;
        first    = (fill_q == '0);
        len_bad  = first && ({16'd0, wr_data[15:0]} > 32'(MAX_LEN));
        room     = ((FW+1)'(fill_q) + (FW+1)'(4)) <= (FW+1)'(DEPTH);
        store    = wr_fire && !len_bad && room && !err_ack;
        fill_nxt = store ? fill_q + FW'(4) : fill_q;
        len_nxt  = (store && first) ? wr_data[15:0] : len_q;
        launch   = (state_q == ST_FILL) && !err_ack &&
                   ((wr_fire && !len_bad && auto_ok) || tx_go);
        ram_addr = (state_q == ST_SEND) ? rd_addr : fill_q[AW-1:0];
    end

    txfa_eval #(.DEPTH(DEPTH)) u_eval (
        .fill    (fill_nxt),
        .len     (len_nxt),
        .cfg     (cfg),
        .auto_ok (auto_ok),
        .flen    (flen),
        .pay_end (pay_end)
    );

    txfa_ram #(.DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (store),
        .addr  (ram_addr),
        .wdata (wr_data),
        .rbyte (ram_byte)
    );

    txfa_stream #(.AW(AW)) u_stream (
        .clk      (clk),
        .rst      (rst),
        .start    (launch),
        .flen     (flen),
        .pay_end  (pay_end),
        .ram_byte (ram_byte),
        .m_ready  (m_ready),
        .m_valid  (m_valid),
        .m_data   (m_data),
        .m_last   (m_last),
        .rd_addr  (rd_addr),
        .done     (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
            fill_q  <= '0;
            len_q   <= '0;
            err_q   <= 1'b0;
            empty_q <= 1'b0;
        end else begin
            err_q   <= wr_fire && len_bad;
            empty_q <= done;
            case (state_q)
                ST_FILL: begin
                    if (err_ack) begin
                        fill_q <= '0;
                    end else begin
                        fill_q <= fill_nxt;
                        len_q  <= len_nxt;
                        if (launch) state_q <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (done) begin
                        state_q <= ST_FILL;
                        fill_q  <= '0;
                    end
                end
                default: state_q <= ST_FILL;
            endcase
        end
    end

    assign err_pulse   = err_q;
    assign empty_pulse = empty_q;

    // R2
    reject_keeps_empty_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> (fill_q == '0));

    // R9
    empty_after_send_chk: assert property (@(posedge clk) disable iff (rst)
        empty_pulse |-> (fill_q == '0 && wr_ready && !m_valid));

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        ({{(32-FW){1'b0}}, fill_q} <= 32'(DEPTH)));

    // R12
    fill_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (m_valid && $past(m_valid)) |-> $stable(fill_q));
endmodule

// File: tb/tb_tx_frame_assembler.sv
module tb_tx_frame_assembler;

    localparam int unsigned DEPTH = 64;

    typedef struct packed {
        logic [15:0] len;
        logic [7:0]  nwords;
        logic        pad;
        logic        crc_auto;
        logic [5:0]  thr;
        logic        use_go;
        logic        bp;
        logic [15:0] exp_len;
    } vec_t;

    // len, words, pad, crc_auto, thr, go, backpressure, expected length
    localparam vec_t VEC [8] = '{
        '{16'd10, 8'd7,  1'b0, 1'b1, 6'd0,  1'b0, 1'b1, 16'd24},
        '{16'd10, 8'd8,  1'b1, 1'b0, 6'd0,  1'b0, 1'b0, 16'd60},
        '{16'd10, 8'd9,  1'b0, 1'b1, 6'd1,  1'b0, 1'b0, 16'd24},
        '{16'd30, 8'd12, 1'b1, 1'b1, 6'h3F, 1'b1, 1'b0, 16'd60},
        '{16'd48, 8'd16, 1'b0, 1'b1, 6'd1,  1'b0, 1'b1, 16'd62},
        '{16'd48, 8'd16, 1'b1, 1'b0, 6'd0,  1'b0, 1'b0, 16'd62},
        '{16'd0,  8'd4,  1'b0, 1'b1, 6'd0,  1'b0, 1'b0, 16'd14},
        '{16'd20, 8'd16, 1'b0, 1'b1, 6'd2,  1'b1, 1'b0, 16'd34}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_pad_en = 1'b0, cfg_crc_auto = 1'b1;
    logic [5:0]  cfg_thr = 6'h3F;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        tx_go = 1'b0, err_ack = 1'b0, m_ready = 1'b0;
    logic        wr_ready, m_valid, m_last, err_pulse, empty_pulse;
    logic [7:0]  m_data;

    int nchk = 0, nfail = 0;
    logic [7:0] shadow [DEPTH];
    int bfill = 0;

    always #5 clk = ~clk;

    tx_frame_assembler #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .cfg_pad_en(cfg_pad_en), .cfg_crc_auto(cfg_crc_auto),
        .cfg_thr(cfg_thr), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .tx_go(tx_go), .err_ack(err_ack), .m_valid(m_valid), .m_data(m_data),
        .m_last(m_last), .m_ready(m_ready), .err_pulse(err_pulse), .empty_pulse(empty_pulse)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int v, input int off);
        return 8'((v * 29 + off * 7 + 5) & 255);
    endfunction

    // starts and ends at a falling edge; store says whether R2/R11 let it in
    task automatic put_word(input logic [31:0] w, input logic store);
        wr_valid = 1'b1;
        wr_data  = w;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        if (store) begin
            for (int b = 0; b < 4; b++) shadow[bfill + b] = w[8*b +: 8];
            bfill += 4;
        end
    endtask

    task automatic pulse_go();
        tx_go = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_go = 1'b0;
    endtask

    task automatic pulse_ack();
        err_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        err_ack = 1'b0;
        bfill = 0;
    endtask

    task automatic fill_frame(input int v, input int len, input int nwords);
        for (int w = 0; w < nwords; w++) begin
            logic [31:0] word;
            for (int b = 0; b < 4; b++) word[8*b +: 8] = pat(v, 4*w + b);
            if (w == 0) word[15:0] = 16'(len);
            put_word(word, (bfill + 4) <= DEPTH);
            if (w < nwords - 1)
                check(m_valid == 1'b0, "R5 no early launch", int'(m_valid), 0);
        end
    endtask

    task automatic recv_frame(input int exp_len, input int len, input logic bp, input string tag);
        int cnt = 0;
        logic got_last = 1'b0;
        for (int k = 0; k < 400 && !got_last; k++) begin
            m_ready = bp ? (k % 3 != 2) : 1'b1;
            #1;
            if (m_valid) check(wr_ready == 1'b0, "R12 wr_ready low while sending", int'(wr_ready), 0);
            if (m_valid && m_ready) begin
                logic [7:0] exp_b;
                exp_b = (cnt >= len + 14) ? 8'h00 : shadow[cnt + 2];
                check(m_data == exp_b, {tag, " R1/R8 byte"}, int'(m_data), int'(exp_b));
                if (m_last) begin
                    got_last = 1'b1;
                    check(cnt + 1 == exp_len, {tag, " R7 frame length"}, cnt + 1, exp_len);
                end
                cnt++;
            end
            @(posedge clk);
            @(negedge clk);
        end
        m_ready = 1'b0;
        check(got_last, {tag, " R7 last byte seen"}, int'(got_last), 1);
        check(empty_pulse == 1'b1, {tag, " R9 empty pulse"}, int'(empty_pulse), 1);
        check(m_valid == 1'b0 && wr_ready == 1'b1, {tag, " R9 idle again"}, int'(m_valid), 0);
        bfill = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) shadow[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        check(m_valid == 1'b0, "R9 reset m_valid", int'(m_valid), 0);
        check(wr_ready == 1'b1, "R12 reset wr_ready", int'(wr_ready), 1);
        check(err_pulse == 1'b0 && empty_pulse == 1'b0, "R2 reset pulses", int'(err_pulse), 0);

        // table of vectors: R3 R4 R5 R6 R7 R8
        for (int v = 0; v < 8; v++) begin
            cfg_pad_en   = VEC[v].pad;
            cfg_crc_auto = VEC[v].crc_auto;
            cfg_thr      = VEC[v].thr;
            fill_frame(v, int'(VEC[v].len), int'(VEC[v].nwords));
            if (VEC[v].use_go) begin
                check(m_valid == 1'b0, "R4 no auto launch", int'(m_valid), 0);
                pulse_go();
                check(m_valid == 1'b1, "R6 command launch", int'(m_valid), 1);
            end else begin
                check(m_valid == 1'b1, "R3/R5 auto launch", int'(m_valid), 1);
            end
            recv_frame(int'(VEC[v].exp_len), int'(VEC[v].len), VEC[v].bp, $sformatf("vec%0d", v));
        end

        // R2: oversize length word rejected
        cfg_pad_en = 1'b0; cfg_crc_auto = 1'b1; cfg_thr = 6'd0;
        put_word(32'h5A5A_0031, 1'b0);
        check(err_pulse == 1'b1, "R2 error pulse", int'(err_pulse), 1);
        check(m_valid == 1'b0, "R2 no launch on reject", int'(m_valid), 0);
        fill_frame(20, 8, 6);
        check(err_pulse == 1'b0, "R2 pulse one cycle", int'(err_pulse), 0);
        check(m_valid == 1'b1, "R2 next word is length", int'(m_valid), 1);
        recv_frame(22, 8, 1'b0, "r2_frame");

        // R10: acknowledge clears the fill level
        cfg_thr = 6'h3F;
        fill_frame(21, 10, 3);
        pulse_ack();
        fill_frame(22, 4, 5);
        pulse_go();
        check(m_valid == 1'b1, "R10 command launch", int'(m_valid), 1);
        recv_frame(18, 4, 1'b0, "r10_frame");

        // R11: write past a full buffer is dropped
        fill_frame(23, 48, 16);
        put_word(32'hDEAD_BEEF, 1'b0);
        check(m_valid == 1'b0, "R11 no launch", int'(m_valid), 0);
        pulse_go();
        recv_frame(62, 48, 1'b1, "r11_frame");

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule